// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit settles conditional branches and jumps while the instruction is still in decode in a five-stage in-order pipeline. It takes the decoded operation class, the two operand values as already resolved by forwarding, the branch PC and a sign-extended word offset. It decides whether the branch is taken, computes the redirect address and drives fetch. Because the decision happens in decode, only one sequential instruction has been fetched behind the branch when the redirect arrives.

A mode input selects how that single wrong-path instruction is handled. In squash mode, the sequential instruction is fetched on a not-taken guess and turned into one bubble when the branch is taken. In delayed mode, it is an architectural delay slot that always completes, so no flush is ever raised, and the link address for jump-and-link skips the slot. A hold input from the hazard unit stops the decision for a cycle when an operand is not yet valid. All outputs are registered and take effect in the cycle after decode.

Top module: `brx_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, all outputs (redirect, target_pc, flush_fd, link_we, link_addr) are zero.
- R2: Operation class codes are 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 jump-and-link; codes 5 to 7 act as none. Equal-branch is taken exactly when opnd_a equals opnd_b, and not-equal-branch exactly when they differ.
- R3: Jump and jump-and-link are always taken, whatever the operands hold.
- R4: When redirect is high, target_pc equals br_pc + 4 + (br_offset << 2), modulo 2^32.
- R5: In squash mode (delay_mode = 0), flush_fd is high exactly when redirect is high, and low for a not-taken branch.
- R6: In delayed mode (delay_mode = 1), flush_fd stays low for every operation.
- R7: link_we is high only for jump-and-link; link_addr then equals br_pc + 4 in squash mode and br_pc + 8 in delayed mode, and is zero otherwise.
- R8: When hold is high in decode, the next cycle shows redirect, flush_fd and link_we low; the decision is made in the first cycle with hold low, on the operands present then.
- R9: Outputs reflect the decode inputs of the previous clock cycle; an operation of class none gives no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delay_mode | input | 1 | 1 = delay-slot mode, 0 = squash mode |
| hold | input | 1 | Hazard hold: defer the decision this cycle |
| op_class | input | 3 | Decoded operation class |
| opnd_a | input | 32 | First resolved register operand |
| opnd_b | input | 32 | Second resolved register operand |
| br_pc | input | 32 | PC of the instruction in decode |
| br_offset | input | 32 | Sign-extended word offset |
| redirect | output | 1 | Next-PC select: 1 = take target_pc |
| target_pc | output | 32 | Redirect address |
| flush_fd | output | 1 | Turn the fetch/decode register into a bubble |
| link_we | output | 1 | Jump-and-link writes the link register |
| link_addr | output | 32 | Return address to write |

## Verification
The bench sweeps every operation class, including the unused codes, in both modes and with hold on and off, against operand pairs that are equal, differ by one bit, or differ only in the sign bit, so a comparator that checks too few bits or inverts the wrong sense shows a wrong redirect. Offsets of zero, positive, minus one and minus two catch a target adder that forgets the four, the shift or the sign. Delayed-mode runs catch a design that still flushes or links to PC+4, which would discard or skip the delay slot. Hold cycles are followed by a change of operands, so a unit that resolved on stale data redirects on the wrong outcome.

// File: rtl/brx_pkg.sv
package brx_pkg;

    localparam int XLEN      = 32;
    localparam int OPW       = 3;
    localparam int INSN_BYTES = 4;
    localparam int WORD_SHIFT = 2;

    typedef enum logic [OPW-1:0] {
        OP_NONE = 3'd0,
        OP_BEQ  = 3'd1,
        OP_BNE  = 3'd2,
        OP_JMP  = 3'd3,
        OP_JAL  = 3'd4
    } op_e;

    typedef struct packed {
        logic            redirect;
        logic            flush;
        logic            link_we;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] link;
    } decision_t;

    function automatic logic is_cond(input logic [OPW-1:0] op);
        return (op == OP_BEQ) || (op == OP_BNE);
    endfunction

    function automatic logic is_uncond(input logic [OPW-1:0] op);
        return (op == OP_JMP) || (op == OP_JAL);
    endfunction

endpackage

// File: rtl/brx_compare.sv
module brx_compare
    import brx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] op,
    output logic           taken
);
    logic [W-1:0] diff;
    logic         same;

    // bitwise difference reduced to a single equality flag
    assign diff = a ^ b;
    assign same = ~|diff;

    always_comb begin
        taken = 1'b0;
        if (is_uncond(op)) begin
            taken = 1'b1;
        end else if (is_cond(op)) begin
            // one comparator, sense inverted for not-equal
            taken = (op == OP_BNE) ? ~same : same;
        end
    end
endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int SHIFT = WORD_SHIFT,
    parameter int STEP  = INSN_BYTES
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] offset,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] target
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    assign seq_pc = pc + STEP_V;
    assign target = seq_pc + (offset << SHIFT);
endmodule

// File: rtl/brx_link.sv
module brx_link
    import brx_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int STEP = INSN_BYTES
) (
    input  logic [W-1:0]   seq_pc,
    input  logic           delayed,
    input  logic [OPW-1:0] op,
    output logic           link_we,
    output logic [W-1:0]   link
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_comb begin
        link_we = (op == OP_JAL);
        link    = '0;
        if (link_we) begin
            // delay-slot mode returns past the slot
            link = delayed ? (seq_pc + STEP_V) : seq_pc;
        end
    end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             delay_mode,
    input  logic             hold,
    input  logic [OPW-1:0]   op_class,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [XLEN-1:0]  br_pc,
    input  logic [XLEN-1:0]  br_offset,
    output logic             redirect,
    output logic [XLEN-1:0]  target_pc,
    output logic             flush_fd,
    output logic             link_we,
    output logic [XLEN-1:0]  link_addr
);
    logic            taken_c;
    logic [XLEN-1:0] seq_pc_c;
    logic [XLEN-1:0] target_c;
    logic            link_we_c;
    logic [XLEN-1:0] link_c;
    decision_t       next_d;
    decision_t       dec_q;

    brx_compare #(.W(XLEN)) u_cmp (
        .a     (opnd_a),
        .b     (opnd_b),
        .op    (op_class),
        .taken (taken_c)
    );

    brx_target #(.W(XLEN), .SHIFT(WORD_SHIFT), .STEP(INSN_BYTES)) u_tgt (
        .pc     (br_pc),
        .offset (br_offset),
        .seq_pc (seq_pc_c),
        .target (target_c)
    );

    brx_link #(.W(XLEN), .STEP(INSN_BYTES)) u_lnk (
        .seq_pc  (seq_pc_c),
        .delayed (delay_mode),
        .op      (op_class),
        .link_we (link_we_c),
        .link    (link_c)
    );

    always_comb begin
        next_d = '0;
        if (!hold && taken_c) begin
            next_d.redirect = 1'b1;
            next_d.target   = target_c;
            next_d.flush    = ~delay_mode;
        end
        if (!hold && link_we_c) begin
            next_d.link_we = 1'b1;
            next_d.link    = link_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= next_d;
        end
    end

    assign redirect  = dec_q.redirect;
    assign target_pc = dec_q.target;
    assign flush_fd  = dec_q.flush;
    assign link_we   = dec_q.link_we;
    assign link_addr = dec_q.link;
endmodule

// File: rtl/brx_unit_chk.sv
module brx_unit_chk
    import brx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             delay_mode,
    input logic             hold,
    input logic [OPW-1:0]   op_class,
    input logic [XLEN-1:0]  opnd_a,
    input logic [XLEN-1:0]  opnd_b,
    input logic             redirect,
    input logic             flush_fd,
    input logic             link_we
);
    logic seen_edge;
    always_ff @(posedge clk) begin
        seen_edge <= ~rst;
    end

    // flush only ever accompanies a redirect
    assert_flush_needs_redirect_R5: assert property (@(posedge clk) disable iff (rst)
        flush_fd |-> redirect);

    // delayed mode never flushes
    assert_no_flush_delayed_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && $past(delay_mode)) |-> !flush_fd);

    // a held decode makes no decision
    assert_hold_defers_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && $past(hold)) |-> (!redirect && !link_we));

    // link write only on a taken jump-and-link
    assert_link_is_jal_R7: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redirect);

    // equal operands on a not-equal branch never redirect
    assert_bne_equal_not_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (op_class == OP_BNE && opnd_a == opnd_b) |=> !redirect);

    // unconditional class redirects next cycle when not held
    assert_jump_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold && (op_class == OP_JMP || op_class == OP_JAL)) |=> redirect);

    // class none gives no redirect
    assert_none_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (op_class == OP_NONE) |=> !redirect);
endmodule

bind brx_unit brx_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .delay_mode (delay_mode),
    .hold       (hold),
    .op_class   (op_class),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .redirect   (redirect),
    .flush_fd   (flush_fd),
    .link_we    (link_we)
);

// File: tb/brx_unit_test.sv
module brx_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        delay_mode;
    logic        hold;
    logic [2:0]  op_class;
    logic [31:0] opnd_a, opnd_b, br_pc, br_offset;
    logic        redirect, flush_fd, link_we;
    logic [31:0] target_pc, link_addr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    brx_unit uut (
        .clk(clk), .rst(rst), .delay_mode(delay_mode), .hold(hold),
        .op_class(op_class), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .br_pc(br_pc), .br_offset(br_offset),
        .redirect(redirect), .target_pc(target_pc), .flush_fd(flush_fd),
        .link_we(link_we), .link_addr(link_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one register)
    task automatic step(input logic md, input logic hd, input logic [2:0] op,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] pc, input logic [31:0] off);
        logic tk, ex_red, ex_fl, ex_lw;
        logic [31:0] ex_ln;
        delay_mode = md; hold = hd; op_class = op;
        opnd_a = a; opnd_b = b; br_pc = pc; br_offset = off;
        case (op)
            3'd1: tk = (a == b);
            3'd2: tk = (a != b);
            3'd3, 3'd4: tk = 1'b1;
            default: tk = 1'b0;
        endcase
        ex_red = tk && !hd;
        ex_fl  = ex_red && !md;
        ex_lw  = (op == 3'd4) && !hd;
        ex_ln  = ex_lw ? (pc + (md ? 32'd8 : 32'd4)) : 32'd0;
        @(negedge clk);
        if (hd) chk("R8 hold redirect", {31'd0, redirect}, 32'd0);
        else if (op == 3'd3 || op == 3'd4) chk("R3 jump redirect", {31'd0, redirect}, 32'd1);
        else if (op == 3'd1 || op == 3'd2) chk("R2 cond redirect", {31'd0, redirect}, {31'd0, ex_red});
        else chk("R9 none redirect", {31'd0, redirect}, 32'd0);
        if (md) chk("R6 delayed flush", {31'd0, flush_fd}, 32'd0);
        else    chk("R5 squash flush", {31'd0, flush_fd}, {31'd0, ex_fl});
        if (ex_red) chk("R4 target", target_pc, pc + 32'd4 + (off << 2));
        chk("R7 link_we", {31'd0, link_we}, {31'd0, ex_lw});
        chk("R7 link_addr", link_addr, ex_ln);
    endtask

    initial begin
        #4_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] av [5];
        logic [31:0] bv [5];
        logic [31:0] ov [5];
        av = '{32'h0, 32'h1234_5678, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000};
        bv = '{32'h0, 32'h1234_5678, 32'h3, 32'hFFFF_FFFF, 32'h0000_0000};
        ov = '{32'h0, 32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0400};
        rst = 1'b1; delay_mode = 1'b0; hold = 1'b0; op_class = 3'd1;
        opnd_a = 0; opnd_b = 0; br_pc = 32'h100; br_offset = 32'h5;
        @(negedge clk); @(negedge clk);
        // R1: reset clears every output even with a taken branch on the inputs
        chk("R1 redirect", {31'd0, redirect}, 32'd0);
        chk("R1 flush", {31'd0, flush_fd}, 32'd0);
        chk("R1 target", target_pc, 32'd0);
        chk("R1 link", {31'd0, link_we} | link_addr, 32'd0);
        op_class = 3'd0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {31'd0, redirect}, 32'd0);

        for (int m = 0; m < 2; m++)
            for (int h = 0; h < 2; h++)
                for (int op = 0; op < 8; op++)
                    for (int p = 0; p < 5; p++)
                        for (int o = 0; o < 5; o++)
                            step(m[0], h[0], op[2:0], av[p], bv[p],
                                 32'h0040_0000 + 32'(p * 64 + o * 4), ov[o]);

        // R8: held on stale equal operands, then resolves on new unequal ones
        for (int m = 0; m < 2; m++) begin
            step(m[0], 1'b1, 3'd1, 32'h5, 32'h5, 32'h2000, 32'h8);
            step(m[0], 1'b0, 3'd1, 32'h5, 32'h6, 32'h2000, 32'h8);
            step(m[0], 1'b1, 3'd2, 32'h5, 32'h6, 32'h2000, 32'h8);
            step(m[0], 1'b0, 3'd2, 32'h5, 32'h6, 32'h2000, 32'h8);
        end
        // R9: back-to-back decisions each land one cycle later
        step(1'b0, 1'b0, 3'd3, 0, 0, 32'hFFFF_FFF8, 32'h1);
        step(1'b0, 1'b0, 3'd0, 0, 0, 32'h3000, 32'h1);
        step(1'b1, 1'b0, 3'd4, 0, 0, 32'hFFFF_FFFC, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule